// File: doc/BRIEF.md
# Drive Ready-Line Polling Monitor

This block watches the ready lines of four disk drives while the controller has no command in progress. It steps a 2-bit unit-select output through drives 0 to 3 and holds each code for a fixed dwell. Drives 0 to 2 get a short dwell and drive 3 gets a dwell twice as long. At the end of each dwell it samples the selected drive's ready input. It compares that sample with the last ready state it recorded for the drive. When the two differ, it records the new state, marks an interrupt pending for that drive, and raises the interrupt output.

The host drains these events one at a time with a sense request. Each request returns a status byte for the lowest-numbered pending drive and clears that entry. When nothing is pending, the reply is the invalid-command code. After reset is released the block first waits about 1.024 ms. If the ready input was high on the last reset cycle, it then posts an interrupt for drive 0 and starts polling. A busy input, held high while a command executes, freezes polling and the startup wait. All timing is derived from the `CLK_KHZ` parameter.

Top module: `drive_ready_poller`

## Requirements
- R1: While reset is asserted (synchronous, active low), and on the first cycle after it: `unit_sel_o` is 0, `irq_o` is 0 and `sense_vld_o` is 0. Every drive's recorded ready state is cleared to "not ready".
- R2: After reset is released, the block waits RST_CYC = CLK_KHZ*1024/1000 clock cycles. If `rdy_i` was high on the last reset cycle, drive 0 becomes pending exactly at the end of that wait, with status byte 0xC0. If `rdy_i` was low, nothing becomes pending.
- R3: Polling starts when the post-reset wait ends. `unit_sel_o` steps 0,1,2,3,0 and only ever increments by one. It holds codes 0 to 2 for CLK_KHZ*220/1000 cycles each and code 3 for CLK_KHZ*440/1000 cycles.
- R4: At the last cycle of each dwell, `rdy_i` is compared with the selected drive's recorded state. A mismatch records the new state, marks that drive pending and raises `irq_o`. A match changes nothing.
- R5: A drive's status byte has bits 7:6 = 11 and bits 5:4 = 00. Bit 3 is 1 if the last detected change left the drive not ready. Bit 2 is 0. Bits 1:0 hold the unit number.
- R6: A sense request sampled at one clock edge produces `sense_vld_o` high for exactly the following cycle, carrying the status byte of the lowest-numbered pending drive. That drive's pending entry is cleared. `irq_o` is high exactly while any drive is pending.
- R7: A sense request while nothing is pending returns 0x80.
- R8: While `busy_i` is high, `unit_sel_o` holds, the dwell and startup timers freeze, and no new drive becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busy_i | input | 1 | Command executing; suspends polling |
| rdy_i | input | 1 | Ready line of the currently selected drive |
| sense_req_i | input | 1 | One-cycle request for the next interrupt status |
| unit_sel_o | output | 2 | Drive currently being polled |
| irq_o | output | 1 | Interrupt request, high while any drive is pending |
| sense_vld_o | output | 1 | Status byte valid, one cycle after a request |
| sense_st0_o | output | 8 | Returned status byte |

## Verification
The assertions assume that `busy_i`, `sense_req_i` and `rdy_i` are synchronous to `clk` and always carry known values. The interrupt-falling check also assumes that pending entries are cleared only by sense requests, never by anything that happens during busy periods. The bench meets these assumptions by changing every input at the falling edge. It models the four ready lines as a vector that is indexed by `unit_sel_o`. Within a random round it keeps that vector constant, so each drive is sampled at least once after any change.

// File: rtl/poll_pkg.sv
package poll_pkg;
    localparam int NUNIT = 4;
    localparam int UW    = 2;

    typedef enum logic {
        PS_WAIT = 1'b0,
        PS_POLL = 1'b1
    } poll_state_e;

    typedef struct packed {
        poll_state_e      state;
        logic [UW-1:0]    sel;
        logic [NUNIT-1:0] known;
        logic [NUNIT-1:0] pend;
        logic [NUNIT-1:0] offl;
        logic             rst_rdy;
        logic             vld;
        logic [7:0]       st0;
    } poll_regs_t;
endpackage

// File: rtl/poll_dwell_timer.sv
module poll_dwell_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == limit - CW'(1));
        cnt_d = cnt_q;
        if (done)     cnt_d = '0;
        else if (run) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/poll_pick_lowest.sv
module poll_pick_lowest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/drive_ready_poller.sv
module drive_ready_poller
    import poll_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy_i,
    input  logic        rdy_i,
    input  logic        sense_req_i,
    output logic [1:0]  unit_sel_o,
    output logic        irq_o,
    output logic        sense_vld_o,
    output logic [7:0]  sense_st0_o
);
    localparam int unsigned SHORT_CYC = CLK_KHZ * 220 / 1000;
    localparam int unsigned LONG_CYC  = CLK_KHZ * 440 / 1000;
    localparam int unsigned RST_CYC   = CLK_KHZ * 1024 / 1000;
    localparam int unsigned MAX_CYC   = (RST_CYC > LONG_CYC) ? RST_CYC : LONG_CYC;
    localparam int          CW        = $clog2(MAX_CYC + 1);

    poll_regs_t r_d, r_q;

    logic          tmr_run;
    logic [CW-1:0] tmr_limit;
    logic          tmr_done;
    logic          pick_any;
    logic [UW-1:0] pick_idx;

    always_comb begin
        if (r_q.state == PS_WAIT)        tmr_limit = CW'(RST_CYC);
        else if (r_q.sel == UW'(NUNIT-1)) tmr_limit = CW'(LONG_CYC);
        else                              tmr_limit = CW'(SHORT_CYC);
    end

    assign tmr_run = !busy_i;

    poll_dwell_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    poll_pick_lowest #(.N(NUNIT), .IW(UW)) u_pick (
        .req (r_q.pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;

        // host drains one pending drive per request (R6, R7)
        if (sense_req_i) begin
            r_d.vld = 1'b1;
            if (pick_any) begin
                r_d.st0           = {2'b11, 2'b00, r_q.offl[pick_idx], 1'b0, pick_idx};
                r_d.pend[pick_idx] = 1'b0;
            end else begin
                r_d.st0 = 8'h80;
            end
        end

        // dwell or startup wait complete; new events override a clear
        if (tmr_done) begin
            if (r_q.state == PS_WAIT) begin
                r_d.state = PS_POLL;
                if (r_q.rst_rdy) begin
                    r_d.pend[0]  = 1'b1;
                    r_d.offl[0]  = 1'b0;
                    r_d.known[0] = 1'b1;
                end
            end else begin
                if (rdy_i != r_q.known[r_q.sel]) begin
                    r_d.known[r_q.sel] = rdy_i;
                    r_d.pend[r_q.sel]  = 1'b1;
                    r_d.offl[r_q.sel]  = !rdy_i;
                end
                r_d.sel = r_q.sel + UW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= PS_WAIT;
            r_q.rst_rdy <= rdy_i;
        end else begin
            r_q <= r_d;
        end
    end

    assign unit_sel_o  = r_q.sel;
    assign irq_o       = |r_q.pend;
    assign sense_vld_o = r_q.vld;
    assign sense_st0_o = r_q.st0;
endmodule

// File: rtl/poll_checker.sv
module poll_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       sense_req_i,
    input logic [1:0] unit_sel_o,
    input logic       irq_o,
    input logic       sense_vld_o,
    input logic [7:0] sense_st0_o
);
    AST_SEL_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(unit_sel_o));                                     // R8
    AST_NO_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !irq_o) |=> !irq_o);                                      // R8
    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(unit_sel_o) |-> unit_sel_o == $past(unit_sel_o) + 2'd1);    // R3
    AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        sense_req_i |=> sense_vld_o);                                        // R6
    AST_NO_SPURIOUS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_req_i |=> !sense_vld_o);                                      // R6
    AST_ST0_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        sense_vld_o |-> (sense_st0_o[7] && sense_st0_o[5:4] == 2'b00 && !sense_st0_o[2])); // R5
    AST_IRQ_FALL_BY_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(sense_req_i));                                // R6
endmodule

bind drive_ready_poller poll_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .sense_req_i (sense_req_i),
    .unit_sel_o  (unit_sel_o),
    .irq_o       (irq_o),
    .sense_vld_o (sense_vld_o),
    .sense_st0_o (sense_st0_o)
);

// File: tb/drive_ready_poller_tb.sv
module drive_ready_poller_tb;
    localparam int unsigned KHZ   = 50;
    localparam int          SHORT = KHZ * 220 / 1000;  // 11
    localparam int          LONG  = KHZ * 440 / 1000;  // 22
    localparam int          RSTC  = KHZ * 1024 / 1000; // 51
    localparam int          SWEEP = 3 * SHORT + LONG + 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       req = 1'b0;
    logic [3:0] rv = 4'b0001;
    logic [3:0] known;
    logic [1:0] sel;
    logic       irq, vld, rdy;
    logic [7:0] st0;
    int         tests = 0;
    int         fails = 0;

    always #10 clk = ~clk;

    assign rdy = rv[sel];

    drive_ready_poller #(.CLK_KHZ(KHZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .rdy_i(rdy), .sense_req_i(req),
        .unit_sel_o(sel), .irq_o(irq), .sense_vld_o(vld), .sense_st0_o(st0)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_st0(input int unit, input logic now_rdy);
        return {2'b11, 2'b00, !now_rdy, 1'b0, 2'(unit)};
    endfunction

    task automatic sense(output logic [7:0] b, output logic v);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        v = vld;
        b = st0;
        @(negedge clk);
    endtask

    // drain and compare against the changes between old and new ready vectors
    task automatic drain(input logic [3:0] oldv, input logic [3:0] newv, input string tag);
        logic [7:0] b;
        logic v;
        for (int u = 0; u < 4; u++) begin
            if (oldv[u] != newv[u]) begin
                sense(b, v);
                chk({tag, " R6 vld"}, v, 1'b1);
                chk({tag, " R5 st0"}, b, exp_st0(u, newv[u]));
            end
        end
        chk({tag, " R6 irq cleared"}, irq, 1'b0);
        sense(b, v);
        chk({tag, " R7 empty"}, b, 8'h80);
    endtask

    initial begin
        #4_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic v;
        int n;
        logic [1:0] hold;
        void'($urandom(32'h5EED));

        repeat (4) @(negedge clk);
        chk("R1 sel", sel, 2'd0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 vld", vld, 1'b0);
        rst_n = 1'b1;
        repeat (RSTC - 1) @(negedge clk);
        chk("R2 not yet", irq, 1'b0);
        @(negedge clk);
        chk("R2 reset irq", irq, 1'b1);
        chk("R3 sel start", sel, 2'd0);
        repeat (SHORT - 1) @(negedge clk);
        chk("R3 dwell0 hold", sel, 2'd0);
        @(negedge clk);
        chk("R3 dwell0 step", sel, 2'd1);
        sense(b, v);
        chk("R2 st0", b, 8'hC0);
        chk("R6 irq low", irq, 1'b0);
        while (sel != 2'd3) @(negedge clk);
        n = 0;
        while (sel == 2'd3) begin n++; @(negedge clk); end
        chk("R3 dwell3", n, LONG);
        known = 4'b0001;

        // reset with ready low: no startup interrupt, all recorded states cleared
        rv = 4'b0000;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sel again", sel, 2'd0);
        chk("R1 irq again", irq, 1'b0);
        rst_n = 1'b1;
        repeat (RSTC + SWEEP) @(negedge clk);
        chk("R2 no irq", irq, 1'b0);
        sense(b, v);
        chk("R7 none", b, 8'h80);
        known = 4'b0000;

        // busy freezes polling
        busy = 1'b1;
        @(negedge clk);
        hold = sel;
        rv = 4'b1111;
        repeat (3 * SWEEP) @(negedge clk);
        chk("R8 irq held", irq, 1'b0);
        chk("R8 sel held", sel, hold);
        busy = 1'b0;
        repeat (SWEEP) @(negedge clk);
        chk("R4 irq after busy", irq, 1'b1);
        drain(known, rv, "busy");
        known = rv;

        // random ready patterns
        for (int k = 0; k < 40; k++) begin
            rv = 4'($urandom);
            repeat (SWEEP) @(negedge clk);
            chk("R4 irq", irq, (rv != known));
            drain(known, rv, "rand");
            known = rv;
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule